// File: doc/BRIEF.md
# Video Blank and Overlay Level Mixer

This block sits in a display pipeline ahead of the per-channel gain stage. On every pixel clock it builds a level code for each of the red, green and blue channels. The code comes from one of three sources: the main 8-bit video sample scaled by a contrast factor, a flat overlay level chosen by that channel's 1-bit overlay colour, or a forced infra-black level while blanking is active. Blanking takes priority over the overlay, and the overlay takes priority over video.

The level scale places infra-black at code 0 and black a fixed offset above it. A common brightness offset is added on top of black. The overlay adds a stepped contrast amount, and a magenta overlay colour can be turned into a light or dark grey on all three channels. All sums saturate at full scale. The result is registered once, so each output is valid one clock after its inputs.

Top module: `vid_osd_mixer`

## Requirements
- R1: While the effective blank is active, all three outputs become 0 (infra-black) on the next clock, whatever the video, overlay and register inputs are.
- R2: `blank_act_low` = 0 makes `blank_in` high mean blanking; `blank_act_low` = 1 makes `blank_in` low mean blanking.
- R3: While `rst_n` is low, all three outputs are 0.
- R4: With no blanking and `ovl_en` low, each output is base + floor(video × `contrast` / 256), where base = BLACK_LVL + floor(`bright` / 4).
- R5: With no blanking and `ovl_en` high, a channel whose overlay bit is 0 outputs base, and its video sample has no effect.
- R6: With no blanking and `ovl_en` high, a channel whose overlay bit is 1 outputs base + `osd_con` × OSD_STEP.
- R7: With no blanking, `ovl_en` high and overlay bits r=1, g=0, b=1, setting `grey_light` makes all three outputs base + floor(`osd_con` × OSD_STEP / 2). Setting only `grey_dark` makes them base + floor(`osd_con` × OSD_STEP / 4). If both bits are set, light grey wins. If both are clear, R5 and R6 apply.
- R8: Any level above 2^LVL_W − 1 (1023 by default) is clamped to 2^LVL_W − 1.
- R9: Each output reflects the inputs sampled at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_r | input | VID_W | Red video sample |
| vid_g | input | VID_W | Green video sample |
| vid_b | input | VID_W | Blue video sample |
| osd_r | input | 1 | Red overlay colour bit |
| osd_g | input | 1 | Green overlay colour bit |
| osd_b | input | 1 | Blue overlay colour bit |
| ovl_en | input | 1 | Overlay insert strobe |
| blank_in | input | 1 | Blanking strobe, sense set by blank_act_low |
| blank_act_low | input | 1 | Blank polarity select |
| bright | input | VID_W | Brightness code |
| contrast | input | VID_W | Video contrast multiplier |
| osd_con | input | OSDC_W | Overlay contrast step count |
| grey_light | input | 1 | Light grey substitution enable |
| grey_dark | input | 1 | Dark grey substitution enable |
| lvl_r | output | LVL_W | Red level code |
| lvl_g | output | LVL_W | Green level code |
| lvl_b | output | LVL_W | Blue level code |

## Verification
The bench keeps the default widths and black offset, but raises OSD_STEP to 70. With that step, a full overlay contrast code overflows the 10-bit scale, so the clamp of R8 can be exercised. With the default step of 40, the clamp cannot be reached at all. The lower steps still cover the unclamped overlay, grey and video sums. The reference model computes each level with plain integer arithmetic, and its source priority matches the order given in the requirements.

// File: rtl/vid_osd_mixer.sv
module vid_osd_mixer #(
  parameter int VID_W     = 8,
  parameter int LVL_W     = 10,
  parameter int OSDC_W    = 4,
  parameter int BLACK_LVL = 32,
  parameter int OSD_STEP  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VID_W-1:0]  vid_r,
  input  logic [VID_W-1:0]  vid_g,
  input  logic [VID_W-1:0]  vid_b,
  input  logic              osd_r,
  input  logic              osd_g,
  input  logic              osd_b,
  input  logic              ovl_en,
  input  logic              blank_in,
  input  logic              blank_act_low,
  input  logic [VID_W-1:0]  bright,
  input  logic [VID_W-1:0]  contrast,
  input  logic [OSDC_W-1:0] osd_con,
  input  logic              grey_light,
  input  logic              grey_dark,
  output logic [LVL_W-1:0]  lvl_r,
  output logic [LVL_W-1:0]  lvl_g,
  output logic [LVL_W-1:0]  lvl_b
);
  localparam int SUM_W   = LVL_W + 8;
  localparam int NCH     = 3;
  localparam logic [SUM_W-1:0] LVL_TOP = SUM_W'((1 << LVL_W) - 1);

  logic                 blank_eff;
  logic                 grey_on;
  logic [SUM_W-1:0]     base_lvl;
  logic [SUM_W-1:0]     osd_full;
  logic [SUM_W-1:0]     grey_add;
  logic [VID_W-1:0]     vid   [NCH];
  logic                 osdb  [NCH];
  logic [LVL_W-1:0]     lvl_q [NCH];

  assign blank_eff = blank_in ^ blank_act_low;
  assign base_lvl  = SUM_W'(BLACK_LVL) + SUM_W'(bright >> 2);
  assign osd_full  = SUM_W'(osd_con) * SUM_W'(OSD_STEP);
  assign grey_on   = ovl_en & osd_r & ~osd_g & osd_b & (grey_light | grey_dark);
  assign grey_add  = grey_light ? (osd_full >> 1) : (osd_full >> 2);

  assign vid[0] = vid_r;
  assign vid[1] = vid_g;
  assign vid[2] = vid_b;
  assign osdb[0] = osd_r;
  assign osdb[1] = osd_g;
  assign osdb[2] = osd_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [2*VID_W-1:0] prod;
    logic [SUM_W-1:0]   raw;
    logic [LVL_W-1:0]   sat;

    assign prod = vid[ch] * contrast;

    always_comb begin
      if (grey_on)
        raw = base_lvl + grey_add;
      else if (ovl_en)
        raw = base_lvl + (osdb[ch] ? osd_full : '0);
      else
        raw = base_lvl + SUM_W'(prod[2*VID_W-1:VID_W]);
    end

    assign sat = (raw > LVL_TOP) ? LVL_TOP[LVL_W-1:0] : raw[LVL_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl_q[ch] <= '0;
      else if (blank_eff)
        lvl_q[ch] <= '0;
      else
        lvl_q[ch] <= sat;
    end
  end

  assign lvl_r = lvl_q[0];
  assign lvl_g = lvl_q[1];
  assign lvl_b = lvl_q[2];

  // R1
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_in ^ blank_act_low) |=> (lvl_r == '0 && lvl_g == '0 && lvl_b == '0));

  // R7
  grey_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(blank_in ^ blank_act_low) && ovl_en && osd_r && !osd_g && osd_b &&
     (grey_light || grey_dark)) |=> (lvl_r == lvl_g && lvl_g == lvl_b));

  // R5
  osd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(blank_in ^ blank_act_low) && ovl_en && !osd_g &&
     !(osd_r && osd_b && (grey_light || grey_dark)))
    |=> (lvl_g == LVL_W'(BLACK_LVL) + LVL_W'($past(bright) >> 2)));

  // R6
  osd_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(blank_in ^ blank_act_low) && ovl_en && osd_g)
    |=> (lvl_g >= LVL_W'(BLACK_LVL) + LVL_W'($past(bright) >> 2)));

  // R4
  zero_con_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(blank_in ^ blank_act_low) && !ovl_en && contrast == '0)
    |=> (lvl_r == LVL_W'(BLACK_LVL) + LVL_W'($past(bright) >> 2)));
endmodule

// File: tb/vid_osd_mixer_tb_top.sv
module vid_osd_mixer_tb_top;
  localparam int STEP = 70;
  localparam int BLK  = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] vid_r = 0, vid_g = 0, vid_b = 0, bright = 0, contrast = 0;
  logic osd_r = 0, osd_g = 0, osd_b = 0, ovl_en = 0, blank_in = 0, blank_act_low = 0;
  logic grey_light = 0, grey_dark = 0;
  logic [3:0] osd_con = 0;
  logic [9:0] lvl_r, lvl_g, lvl_b;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vid_osd_mixer #(.OSD_STEP(STEP), .BLACK_LVL(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
    .osd_r(osd_r), .osd_g(osd_g), .osd_b(osd_b),
    .ovl_en(ovl_en), .blank_in(blank_in), .blank_act_low(blank_act_low),
    .bright(bright), .contrast(contrast), .osd_con(osd_con),
    .grey_light(grey_light), .grey_dark(grey_dark),
    .lvl_r(lvl_r), .lvl_g(lvl_g), .lvl_b(lvl_b));

  function automatic int ref_lvl(int v, bit ob, output string tag);
    int base, full, lv;
    if (blank_in ^ blank_act_low) begin
      tag = blank_act_low ? "R2" : "R1";
      return 0;
    end
    base = BLK + bright / 4;
    full = osd_con * STEP;
    if (ovl_en && osd_r && !osd_g && osd_b && (grey_light || grey_dark)) begin
      tag = "R7";
      lv = base + (grey_light ? full / 2 : full / 4);
    end else if (ovl_en) begin
      tag = ob ? "R6" : "R5";
      lv = base + (ob ? full : 0);
    end else begin
      tag = "R4";
      lv = base + (v * contrast) / 256;
    end
    if (lv > 1023) begin
      tag = "R8";
      lv = 1023;
    end
    return lv;
  endfunction

  // compare one cycle after drive (R9)
  task automatic tick();
    int er, eg, eb;
    string tr, tg, tb;
    bit bad;
    er = ref_lvl(vid_r, osd_r, tr);
    eg = ref_lvl(vid_g, osd_g, tg);
    eb = ref_lvl(vid_b, osd_b, tb);
    @(negedge clk);
    vectors++;
    bad = 0;
    if (lvl_r !== 10'(er)) begin
      $display("FAIL %s/R9 red: actual %0d expected %0d", tr, lvl_r, er); bad = 1;
    end
    if (lvl_g !== 10'(eg)) begin
      $display("FAIL %s/R9 green: actual %0d expected %0d", tg, lvl_g, eg); bad = 1;
    end
    if (lvl_b !== 10'(eb)) begin
      $display("FAIL %s/R9 blue: actual %0d expected %0d", tb, lvl_b, eb); bad = 1;
    end
    if (bad) errors++;
  endtask

  task automatic set_vid(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    vid_r = r; vid_g = g; vid_b = b;
  endtask

  task automatic set_osd(bit en, bit r, bit g, bit b);
    ovl_en = en; osd_r = r; osd_g = g; osd_b = b;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset holds outputs at zero with active inputs
    set_vid(200, 100, 50); bright = 8'd200; contrast = 8'd255;
    repeat (3) @(negedge clk);
    vectors++;
    if (lvl_r !== 0 || lvl_g !== 0 || lvl_b !== 0) begin
      errors++;
      $display("FAIL R3 reset: actual %0d/%0d/%0d expected 0/0/0", lvl_r, lvl_g, lvl_b);
    end
    rst_n = 1;

    // R4 video mode
    bright = 0; contrast = 0; tick();
    bright = 8'd255; contrast = 8'd255; set_vid(255, 128, 1); tick();
    bright = 8'd7; contrast = 8'd128; set_vid(3, 100, 254); tick();

    // R1 blank wins over video and overlay
    blank_in = 1; tick();
    set_osd(1, 1, 1, 1); osd_con = 4'd15; tick();
    blank_in = 0; set_osd(0, 0, 0, 0); tick();

    // R2 active-low blank
    blank_act_low = 1; blank_in = 0; tick();
    blank_in = 1; tick();
    blank_act_low = 0; blank_in = 0;

    // R5/R6 overlay, video ignored
    bright = 8'd40; osd_con = 4'd5;
    set_osd(1, 1, 0, 0); set_vid(255, 255, 255); tick();
    set_vid(0, 0, 0); tick();
    set_osd(1, 0, 1, 1); osd_con = 4'd0; tick();

    // R8 saturation
    osd_con = 4'd15; bright = 8'd255; set_osd(1, 1, 1, 1); tick();
    osd_con = 4'd14; bright = 8'd0; tick();

    // R7 grey modes
    set_osd(1, 1, 0, 1); osd_con = 4'd9; bright = 8'd12;
    grey_light = 1; grey_dark = 0; tick();
    grey_light = 0; grey_dark = 1; tick();
    grey_light = 1; grey_dark = 1; tick();
    grey_light = 0; grey_dark = 0; tick();
    osd_con = 4'd15; grey_light = 1; tick();
    set_osd(0, 1, 0, 1); grey_dark = 1; tick();
    grey_light = 0; grey_dark = 0;

    // mixed patterns
    for (int i = 0; i < 600; i++) begin
      set_vid($urandom, $urandom, $urandom);
      bright = $urandom; contrast = $urandom; osd_con = $urandom;
      set_osd($urandom, $urandom, $urandom, $urandom);
      blank_in = ($urandom % 5) == 0;
      blank_act_low = ($urandom % 4) == 0;
      grey_light = $urandom; grey_dark = $urandom;
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule